// File: doc/BRIEF.md
# Eight-Lane Prime-Field Inverter (modulus 31)

This block takes a vector of eight 16-bit lanes, each holding an integer that stands for an element of the prime field with 31 elements, and returns the multiplicative inverse of every lane at once. Lanes may carry any signed 16-bit representative. The block first folds each lane into its canonical residue 0..30. It then raises that residue to the power 29, which is the modulus minus two. For a nonzero element this power is its inverse.

The power is built by a fixed four-step product chain, with one pipeline stage per step. The steps are the cube, then base times accumulator squared, then a plain square, then base times accumulator squared again. Each step reduces its product back to a residue before the next step uses it, so no intermediate value needs more than 17 bits. A new vector can enter on every cycle. A valid flag travels alongside the data with the same fixed delay. A lane whose input is congruent to zero leaves as zero.

Top module: `gf31_vec_inv`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals the value `in_valid` had exactly 5 clock edges earlier. The latency is fixed at 5 cycles.
- R3: For a lane whose input is not a multiple of 31, the output lane value v lies in 1..30, and v times the input's residue is congruent to 1 modulo 31.
- R4: Every output lane holds a value in 0..30, with bits 15..5 of each lane equal to zero.
- R5: A lane whose input is a multiple of 31 (including 0, 31 and -31) produces 0.
- R6: Inputs are read as two's-complement signed 16-bit values. A negative input is inverted through its residue class, so -1 gives 30 and -32768 gives the inverse of 30.
- R7: Lane i occupies bits 16*i+15 down to 16*i of both `in_data` and `out_data`. Each lane's result depends only on the same lane's input.
- R8: Vectors presented on consecutive cycles each produce their own result on consecutive cycles, 5 cycles later. There are no stalls or bubbles.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as carrying a vector this cycle |
| in_data | input | 128 | Eight signed 16-bit lanes, lane 0 in the low bits |
| out_valid | output | 1 | Marks `out_data` as carrying a result this cycle |
| out_data | output | 128 | Eight lane inverses, each in 0..30 |

## Verification
The checker assumes that `in_data` is a defined two's-complement value on every cycle. It does not assume that `in_data` is defined only while `in_valid` is high, because the data path runs freely. The checker's properties compare each output with the input from five edges earlier, and they are kept off until five edges have passed since reset. The stimulus drives `in_data` and `in_valid` on the falling edge only and never leaves them undriven. It covers every residue class, both ends of the signed range, and idle gaps within a stream.

// File: rtl/gf31_pkg.sv
package gf31_pkg;

    localparam int unsigned GF_Q     = 31;
    localparam int unsigned LANE_W   = 16;
    localparam int unsigned ELEM_W   = 5;
    localparam int unsigned WIDE_W   = 17;
    localparam int unsigned NUM_STEP = 4;
    localparam int unsigned LATENCY  = NUM_STEP + 1;
    // 31 * 1058: smallest multiple of 31 that lifts -32768 to a non-negative value
    localparam logic [WIDE_W-1:0] SIGN_LIFT = 17'd32798;

    typedef logic [ELEM_W-1:0] elem_t;

    typedef enum logic [1:0] {
        STEP_CUBE = 2'd0,   // acc <- base^3
        STEP_BAA  = 2'd1,   // acc <- base * acc * acc
        STEP_SQR  = 2'd2    // acc <- acc * acc
    } step_e;

    typedef struct packed {
        elem_t base;
        elem_t acc;
    } lane_st_t;

    // Since 32 = 1 (mod 31), the upper bits can be added onto the low five bits.
    function automatic elem_t fold31(input logic [WIDE_W-1:0] v);
        logic [WIDE_W-1:0] t;
        t = v;
        t = {5'd0, t[16:5]} + {12'd0, t[4:0]};
        t = {5'd0, t[16:5]} + {12'd0, t[4:0]};
        t = {5'd0, t[16:5]} + {12'd0, t[4:0]};
        if (t >= WIDE_W'(GF_Q)) begin
            t = t - WIDE_W'(GF_Q);
        end
        return t[ELEM_W-1:0];
    endfunction

    function automatic elem_t mul31(input elem_t a, input elem_t b);
        logic [WIDE_W-1:0] p;
        p = {12'd0, a} * {12'd0, b};
        return fold31(p);
    endfunction

    function automatic elem_t norm_signed(input logic [LANE_W-1:0] x);
        logic [WIDE_W-1:0] s;
        s = {x[LANE_W-1], x} + SIGN_LIFT;
        return fold31(s);
    endfunction

endpackage

// File: rtl/gf31_lane_norm.sv
module gf31_lane_norm
    import gf31_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LANE_W-1:0]   raw,
    output lane_st_t            q
);
    lane_st_t nxt;

    always_comb begin
        nxt.base = norm_signed(raw);
        nxt.acc  = nxt.base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/gf31_pow_stage.sv
module gf31_pow_stage
    import gf31_pkg::*;
#(
    parameter step_e STEP = STEP_CUBE
) (
    input  logic     clk,
    input  logic     rst,
    input  lane_st_t d,
    output lane_st_t q
);
    lane_st_t nxt;
    elem_t    first;

    generate
        if (STEP == STEP_CUBE) begin : g_cube
            always_comb begin
                first    = mul31(d.base, d.base);
                nxt.base = d.base;
                nxt.acc  = mul31(first, d.base);
            end
        end else if (STEP == STEP_BAA) begin : g_baa
            always_comb begin
                first    = mul31(d.acc, d.acc);
                nxt.base = d.base;
                nxt.acc  = mul31(first, d.base);
            end
        end else begin : g_sqr
            always_comb begin
                first    = mul31(d.acc, d.acc);
                nxt.base = d.base;
                nxt.acc  = first;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/gf31_vec_inv.sv
module gf31_vec_inv
    import gf31_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] in_data,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_data
);
    localparam int unsigned PAD_W = LANE_W - ELEM_W;
    localparam step_e CHAIN [NUM_STEP] = '{STEP_CUBE, STEP_BAA, STEP_SQR, STEP_BAA};

    logic [LATENCY-1:0] vld_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[LATENCY-2:0], in_valid};
        end
    end

    assign out_valid = vld_sr[LATENCY-1];

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            lane_st_t st [NUM_STEP+1];

            gf31_lane_norm u_norm (
                .clk (clk),
                .rst (rst),
                .raw (in_data[ln*LANE_W +: LANE_W]),
                .q   (st[0])
            );

            for (genvar sp = 0; sp < NUM_STEP; sp++) begin : g_step
                gf31_pow_stage #(.STEP(CHAIN[sp])) u_stage (
                    .clk (clk),
                    .rst (rst),
                    .d   (st[sp]),
                    .q   (st[sp+1])
                );
            end

            assign out_data[ln*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, st[NUM_STEP].acc};
        end
    endgenerate
endmodule

// File: rtl/gf31_vec_inv_chk.sv
module gf31_vec_inv_chk
    import gf31_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [LANES*LANE_W-1:0] in_data,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_data
);
    logic [2:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end
    assign warm = (since_rst >= 3'(LATENCY));

    function automatic int residue(input logic [LANE_W-1:0] x);
        int v;
        v = int'($signed(x)) % 31;
        if (v < 0) v = v + 31;
        return v;
    endfunction

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst || !warm)
        out_valid == $past(in_valid, 5));

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane_chk
            p_range_r4: assert property (@(posedge clk) disable iff (rst)
                out_data[ln*LANE_W +: LANE_W] <= 16'd30);

            p_inverse_r3: assert property (@(posedge clk) disable iff (rst || !warm)
                (residue($past(in_data[ln*LANE_W +: LANE_W], 5)) != 0) |->
                ((int'(out_data[ln*LANE_W +: LANE_W]) *
                  residue($past(in_data[ln*LANE_W +: LANE_W], 5))) % 31 == 1));

            p_zero_r5: assert property (@(posedge clk) disable iff (rst || !warm)
                (residue($past(in_data[ln*LANE_W +: LANE_W], 5)) == 0) |->
                (out_data[ln*LANE_W +: LANE_W] == 16'd0));
        end
    endgenerate
endmodule

bind gf31_vec_inv gf31_vec_inv_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_gf31_vec_inv.sv
module tb_gf31_vec_inv;
    localparam int LANES = 8;
    localparam int DW    = LANES * 16;
    localparam int LAT   = 5;
    localparam int NVEC  = 8;

    // Stimulus vectors; lane 0 is the rightmost 16-bit field (R7).
    localparam logic [DW-1:0] STIM [NVEC] = '{
        {16'd8,  16'd7,  16'd6,  16'd5,  16'd4,  16'd3,  16'd2,  16'd1},
        {16'd16, 16'd15, 16'd14, 16'd13, 16'd12, 16'd11, 16'd10, 16'd9},
        {16'd24, 16'd23, 16'd22, 16'd21, 16'd20, 16'd19, 16'd18, 16'd17},
        {16'd0,  16'd31, 16'd30, 16'd29, 16'd28, 16'd27, 16'd26, 16'd25},
        {16'hFFFF, 16'hFFFE, 16'hFFF1, 16'hFFE1, 16'h8000, 16'h7FFF, 16'd62, 16'd33},
        {16'd1000, 16'd500, 16'd100, 16'd64, 16'd32, 16'hFC18, 16'hFF9C, 16'd93},
        {16'd1, 16'd0, 16'd1, 16'd0, 16'd1, 16'd0, 16'd1, 16'd0},
        {16'd12345, 16'hCFC7, 16'd4321, 16'd7, 16'd2, 16'hFFF0, 16'h0F0F, 16'd3}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    gf31_vec_inv #(.LANES(LANES)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [15:0] ref_inv(input logic [15:0] x);
        int r;
        r = int'($signed(x)) % 31;
        if (r < 0) r = r + 31;
        if (r == 0) return 16'd0;
        for (int k = 1; k < 31; k++) begin
            if ((k * r) % 31 == 1) return 16'(k);
        end
        return 16'hFFFF;
    endfunction

    function automatic logic [DW-1:0] ref_vec(input logic [DW-1:0] v);
        logic [DW-1:0] e;
        for (int i = 0; i < LANES; i++) e[i*16 +: 16] = ref_inv(v[i*16 +: 16]);
        return e;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (3) tick();
        // R1: outputs quiet during reset
        chk("R1 reset valid", {127'd0, out_valid}, '0);
        chk("R1 reset data", out_data, '0);
        rst = 1'b0;

        // R2, R3, R4, R5, R6, R7, R8: table streamed back to back
        for (int n = 0; n < NVEC + LAT; n++) begin
            if (n < NVEC) begin
                in_valid = 1'b1;
                in_data  = STIM[n];
            end else begin
                in_valid = 1'b0;
                in_data  = '0;
            end
            if (n >= LAT) begin
                chk("R8 stream valid", {127'd0, out_valid}, {127'd0, 1'b1});
                chk("R3 R5 R6 R7 stream data", out_data, ref_vec(STIM[n-LAT]));
            end else begin
                chk("R2 not yet valid", {127'd0, out_valid}, '0);
            end
            tick();
        end
        chk("R2 drained", {127'd0, out_valid}, '0);

        // R2: single pulse appears exactly LAT cycles later
        in_valid = 1'b1;
        in_data  = {8{16'h8000}};
        tick();
        in_valid = 1'b0;
        in_data  = {8{16'd5}};
        for (int c = 1; c <= LAT + 1; c++) begin
            if (c == LAT) begin
                chk("R2 pulse valid", {127'd0, out_valid}, {127'd0, 1'b1});
                chk("R6 most negative", out_data, {8{ref_inv(16'h8000)}});
            end else begin
                chk("R2 pulse gap", {127'd0, out_valid}, '0);
            end
            tick();
        end

        // R4: ranges on extreme inputs, R6: -1 gives 30
        in_valid = 1'b1;
        in_data  = {16'h7FFF, 16'hFFFF, 16'h8001, 16'hFFE2, 16'd30, 16'hFFC2, 16'd1, 16'hFFFF};
        tick();
        in_valid = 1'b0;
        repeat (LAT - 1) tick();
        chk("R6 minus one", {112'd0, out_data[15:0]}, {112'd0, 16'd30});
        for (int i = 0; i < LANES; i++)
            chk("R4 lane range", {112'd0, 16'(out_data[i*16 +: 16] > 16'd30)}, '0);

        // R1: reset mid-stream clears valid and data
        in_valid = 1'b1;
        in_data  = {8{16'd3}};
        tick();
        tick();
        rst = 1'b1;
        tick();
        chk("R1 mid reset valid", {127'd0, out_valid}, '0);
        chk("R1 mid reset data", out_data, '0);
        rst      = 1'b0;
        in_valid = 1'b0;
        repeat (LAT + 1) tick();
        chk("R2 no ghost after reset", {127'd0, out_valid}, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule